// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block forms the result and the arithmetic status flags of an add or subtract, at byte or word operand size. The size is chosen on every operation. Four operations are supported: plain add, add with an incoming carry, plain subtract, and subtract with an incoming borrow. When the update enable is high, the result and the six status flags (carry, parity, half-carry, zero, sign, overflow) are registered. When it is low, they hold their previous values.

The same 16-bit flag word also holds three control flags: single-step trap, interrupt enable and string direction. Arithmetic never changes them. Only explicit per-flag set and clear commands do. The execution stage reads the word to steer conditional branches, and it issues the set and clear commands for the control-flag instructions.

Top module: `arith_flag_gen`

## Requirements
- R1: After reset, `result` is 0x0000 and `flags` is 0x0046, so zero and parity agree with the zero result and every control flag is clear.
- R2: `op_sel` encodes 00 = add, 01 = add plus `carry_in`, 10 = subtract, 11 = subtract minus `carry_in`. With `wide` = 1 the 16-bit result is registered. With `wide` = 0 only the low bytes are used, the 8-bit result appears in `result[7:0]` and `result[15:8]` reads zero. Results appear one clock after the operation is presented.
- R3: The carry flag (`flags[0]`) is the carry out of the selected size's top bit on an add, and the borrow into it on a subtract.
- R4: The half-carry flag (`flags[4]`) is the carry out of bit 3 into bit 4 on an add, and the borrow from bit 4 into bit 3 on a subtract.
- R5: The parity flag (`flags[2]`) is 1 when `result[7:0]` holds an even number of ones, at both sizes.
- R6: The zero flag (`flags[6]`) is 1 exactly when the result at the selected size is zero.
- R7: The sign flag (`flags[7]`) equals result bit 7 at byte size and result bit 15 at word size.
- R8: The overflow flag (`flags[11]`) is 1 when the signed result does not fit the selected size. For example, byte 0x7F + 0x01 gives 0x80 with overflow set.
- R9: While `upd_en` is low, `result` and all six status flags keep their values.
- R10: The set and clear commands act on the control flags in `flags[10:8]`. Bit 0 of each command is trap (bit 8), bit 1 is interrupt enable (bit 9) and bit 2 is direction (bit 10). Clear wins over set. The command acts regardless of `upd_en`, and the control flags change for no other reason.
- R11: Flag bit 1 always reads 1. Bits 3, 5 and 15:12 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opa | input | 16 | First operand (minuend on subtract) |
| opb | input | 16 | Second operand (subtrahend on subtract) |
| carry_in | input | 1 | Carry or borrow used by the two carry-chained operations |
| op_sel | input | 2 | Operation select |
| wide | input | 1 | 1 = word size, 0 = byte size |
| upd_en | input | 1 | Register the result and status flags |
| ctl_set | input | 3 | Per-flag set command for trap, interrupt enable, direction |
| ctl_clr | input | 3 | Per-flag clear command, same bit order, dominant over set |
| result | output | 16 | Registered result |
| flags | output | 16 | Registered flag word |

## Verification
The assertions check on every cycle the relations that can be read between the two outputs:
- zero and parity must agree with the registered result;
- sign must follow the top bit of the chosen size;
- the high byte must stay clear after a byte operation;
- result and status must hold while the update enable is low;
- the control flags must follow their set and clear commands and move for no other reason.

Carry, half-carry and overflow depend on the operands, so only the bench's scenarios can show them. The bench compares them against an integer model across random operations and directed edges. These edges include signed wrap at both sizes, borrow out of zero, half-carry on 0x0F + 1, and chained carry and borrow inputs.

// File: rtl/fg_pkg.sv
package fg_pkg;

    localparam int DATA_W = 16;
    localparam int HALF_W = DATA_W / 2;
    localparam int NIB_W  = 4;

    // Flag word bit positions
    localparam int POS_CF = 0;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_OF = 11;
    localparam int NUM_CTL = 3;

    // Bits with a fixed value
    localparam logic [15:0] FIXED_ONES = 16'h0002;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBB = 2'b11
    } op_e;

    typedef struct packed {
        logic                cf;
        logic                pf;
        logic                af;
        logic                zf;
        logic                sf;
        logic                of;
    } status_t;

    typedef struct packed {
        logic [DATA_W-1:0]   res;
        status_t             st;
        logic [NUM_CTL-1:0]  ctl;
    } state_t;

endpackage

// File: rtl/fg_carry_chain.sv
module fg_carry_chain #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic [W:0]   carry
);
    // Subtract runs as a + ~b + ~borrow.
    // carry[i] is the carry entering bit i.
    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bi;
        assign bi         = b[i] ^ sub;
        assign sum[i]     = a[i] ^ bi ^ carry[i];
        assign carry[i+1] = (a[i] & bi) | (carry[i] & (a[i] ^ bi));
    end
endmodule

// File: rtl/fg_parity.sv
module fg_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    output logic         even
);
    logic [W:0] acc;
    assign acc[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_acc
        assign acc[i+1] = acc[i] ^ d[i];
    end

    assign even = acc[W];
endmodule

// File: rtl/fg_status.sv
module fg_status
    import fg_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] sum,
    input  logic [W:0]   carry,
    input  logic         sub,
    input  logic         wide,
    output logic [W-1:0] res,
    output logic         cf,
    output logic         af,
    output logic         zf,
    output logic         sf,
    output logic         of
);
    localparam int H = W / 2;

    logic c_out, c_msb_in;

    always_comb begin
        if (wide) begin
            res      = sum;
            c_out    = carry[W];
            c_msb_in = carry[W-1];
            sf       = sum[W-1];
        end else begin
            res      = {{(W-H){1'b0}}, sum[H-1:0]};
            c_out    = carry[H];
            c_msb_in = carry[H-1];
            sf       = sum[H-1];
        end
        // In the inverted-operand form a missing carry is a borrow
        cf = c_out ^ sub;
        af = carry[NIB_W] ^ sub;
        of = c_out ^ c_msb_in;
        zf = (res == '0);
    end
endmodule

// File: rtl/arith_flag_gen.sv
module arith_flag_gen
    import fg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] opa,
    input  logic [15:0] opb,
    input  logic        carry_in,
    input  logic [1:0]  op_sel,
    input  logic        wide,
    input  logic        upd_en,
    input  logic [2:0]  ctl_set,
    input  logic [2:0]  ctl_clr,
    output logic [15:0] result,
    output logic [15:0] flags
);
    op_e           op;
    logic          is_sub;
    logic          cin_adj;
    logic [DATA_W-1:0] sum;
    logic [DATA_W:0]   carry;
    logic [DATA_W-1:0] res_n;
    logic          cf_n, af_n, zf_n, sf_n, of_n, pf_n;

    state_t state_d, state_q;

    assign op      = op_e'(op_sel);
    assign is_sub  = (op == OP_SUB) || (op == OP_SBB);
    assign cin_adj = (((op == OP_ADC) || (op == OP_SBB)) & carry_in) ^ is_sub;

    fg_carry_chain #(.W(DATA_W)) u_chain (
        .a     (opa),
        .b     (opb),
        .sub   (is_sub),
        .cin   (cin_adj),
        .sum   (sum),
        .carry (carry)
    );

    fg_status #(.W(DATA_W)) u_stat (
        .sum   (sum),
        .carry (carry),
        .sub   (is_sub),
        .wide  (wide),
        .res   (res_n),
        .cf    (cf_n),
        .af    (af_n),
        .zf    (zf_n),
        .sf    (sf_n),
        .of    (of_n)
    );

    fg_parity #(.W(HALF_W)) u_par (
        .d    (res_n[HALF_W-1:0]),
        .even (pf_n)
    );

    always_comb begin
        state_d = state_q;
        if (upd_en) begin
            state_d.res   = res_n;
            state_d.st.cf = cf_n;
            state_d.st.pf = pf_n;
            state_d.st.af = af_n;
            state_d.st.zf = zf_n;
            state_d.st.sf = sf_n;
            state_d.st.of = of_n;
        end
        for (int i = 0; i < NUM_CTL; i++) begin
            if (ctl_clr[i])
                state_d.ctl[i] = 1'b0;
            else if (ctl_set[i])
                state_d.ctl[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.st.zf <= 1'b1;
            state_q.st.pf <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flags                             = FIXED_ONES;
        flags[POS_CF]                     = state_q.st.cf;
        flags[POS_PF]                     = state_q.st.pf;
        flags[POS_AF]                     = state_q.st.af;
        flags[POS_ZF]                     = state_q.st.zf;
        flags[POS_SF]                     = state_q.st.sf;
        flags[POS_TF+NUM_CTL-1:POS_TF]    = state_q.ctl;
        flags[POS_OF]                     = state_q.st.of;
    end

    assign result = state_q.res;
endmodule

// File: rtl/fg_checker.sv
module fg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        upd_en,
    input logic        wide,
    input logic [2:0]  ctl_set,
    input logic [2:0]  ctl_clr,
    input logic [15:0] result,
    input logic [15:0] flags
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> ($stable(result) && $stable({flags[11], flags[7:0]})));

    assert_ctl_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flags[10:8]));

    assert_ctl_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_clr != 3'b000) |=> ((flags[10:8] & $past(ctl_clr)) == 3'b000));

    assert_ctl_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_set & ~ctl_clr) != 3'b000) |=>
            ((flags[10:8] & $past(ctl_set & ~ctl_clr)) == $past(ctl_set & ~ctl_clr)));

    assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flags[6] == (result == 16'h0000));

    assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flags[2] == ~^result[7:0]);

    assert_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !wide) |=> (result[15:8] == 8'h00 && flags[7] == result[7]));

    assert_sign_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && wide) |=> (flags[7] == result[15]));
endmodule

bind arith_flag_gen fg_checker u_fg_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .wide    (wide),
    .ctl_set (ctl_set),
    .ctl_clr (ctl_clr),
    .result  (result),
    .flags   (flags)
);

// File: tb/sim_arith_flag_gen.sv
module sim_arith_flag_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opa = '0, opb = '0;
    logic        carry_in = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic        wide = 1'b0;
    logic        upd_en = 1'b0;
    logic [2:0]  ctl_set = '0, ctl_clr = '0;
    logic [15:0] result, flags;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] exp_res = 16'h0000;
    logic [5:0]  exp_st  = 6'b010100; // cf,pf,af,zf,sf,of
    logic [2:0]  exp_ctl = 3'b000;

    always #4 clk = ~clk;

    arith_flag_gen u0 (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .carry_in(carry_in),
        .op_sel(op_sel), .wide(wide), .upd_en(upd_en), .ctl_set(ctl_set),
        .ctl_clr(ctl_clr), .result(result), .flags(flags)
    );

    function automatic logic [15:0] pack_flags(logic [5:0] st, logic [2:0] c);
        logic [15:0] f;
        f = 16'h0002;
        f[0] = st[5]; f[2] = st[4]; f[4] = st[3];
        f[6] = st[2]; f[7] = st[1]; f[11] = st[0];
        f[10:8] = c;
        return f;
    endfunction

    // Integer model of the arithmetic; returns {result, status}
    function automatic logic [21:0] model(logic [15:0] a, logic [15:0] b,
                                          logic [1:0] op, logic w, logic ci);
        int mask, av, bv, c, r, rr, msb, sa, sb, sr;
        logic cf, af, of, zf, sf, pf;
        mask = w ? 'hFFFF : 'hFF;
        msb  = w ? 15 : 7;
        av = int'(a) & mask;
        bv = int'(b) & mask;
        c  = op[0] ? int'(ci) : 0;
        if (!op[1]) begin
            r  = av + bv + c;
            cf = r > mask;
            af = ((av & 15) + (bv & 15) + c) > 15;
        end else begin
            r  = av - bv - c;
            cf = r < 0;
            af = ((av & 15) - (bv & 15) - c) < 0;
        end
        rr = r & mask;
        sa = (av >> msb) & 1;
        sb = (bv >> msb) & 1;
        sr = (rr >> msb) & 1;
        of = op[1] ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
        zf = (rr == 0);
        sf = sr[0];
        pf = ~^rr[7:0];
        return {rr[15:0], cf, pf, af, zf, sf, of};
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(logic [15:0] a, logic [15:0] b, logic [1:0] op,
                        logic w, logic ci, logic upd, logic [2:0] st,
                        logic [2:0] cl, string tag);
        logic [21:0] m;
        @(negedge clk);
        opa = a; opb = b; op_sel = op; wide = w; carry_in = ci;
        upd_en = upd; ctl_set = st; ctl_clr = cl;
        m = model(a, b, op, w, ci);
        if (upd) begin
            exp_res = m[21:6];
            exp_st  = m[5:0];
        end
        exp_ctl = (exp_ctl | st) & ~cl;
        @(posedge clk);
        #1;
        check({tag, " result"}, result, exp_res);
        check({tag, " flags"},  flags,  pack_flags(exp_st, exp_ctl));
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 result", result, 16'h0000);
        check("R1 flags",  flags,  16'h0046);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: byte signed overflow 7F+01 -> 80, also sign R7 and half-carry R4
        step(16'h007F, 16'h0001, 2'b00, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, "R8 byte 7F+01");
        // R3 R6: word FFFF+1 -> 0, carry and zero
        step(16'hFFFF, 16'h0001, 2'b00, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R3 R6 word wrap");
        // R3: borrow on 0-1 byte
        step(16'h0000, 16'h0001, 2'b10, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, "R3 byte borrow");
        // R8: word 8000-1 signed overflow on subtract
        step(16'h8000, 16'h0001, 2'b10, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R8 word sub");
        // R4: half-carry 0F+01
        step(16'h000F, 16'h0001, 2'b00, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R4 nibble carry");
        // R2: add with carry and subtract with borrow
        step(16'h1234, 16'h0FFF, 2'b01, 1'b1, 1'b1, 1'b1, 3'b000, 3'b000, "R2 adc");
        step(16'h1000, 16'h0FFF, 2'b11, 1'b1, 1'b1, 1'b1, 3'b000, 3'b000, "R2 sbb");
        // R2: byte mode ignores upper bytes, R5 low-byte parity
        step(16'hAB81, 16'hCD02, 2'b00, 1'b0, 1'b1, 1'b1, 3'b000, 3'b000, "R2 R5 byte upper ignored");
        // R7: word sign from bit 15
        step(16'h4000, 16'h4000, 2'b00, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R7 word sign");
        // R9: no update keeps result and status
        step(16'hFFFF, 16'hFFFF, 2'b00, 1'b1, 1'b1, 1'b0, 3'b000, 3'b000, "R9 hold");
        // R10: set, clear priority, independent of update enable
        step(16'h0001, 16'h0001, 2'b00, 1'b1, 1'b0, 1'b0, 3'b111, 3'b000, "R10 set all");
        step(16'h0001, 16'h0001, 2'b00, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R10 arith keeps ctl");
        step(16'h0001, 16'h0001, 2'b00, 1'b1, 1'b0, 1'b1, 3'b010, 3'b011, "R10 clear wins");
        // R11: fixed bits checked with every flags comparison
        step(16'h0000, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, "R11 layout");

        for (int k = 0; k < 400; k++) begin
            logic [2:0] s, c;
            s = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
            c = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
            step(16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom),
                 1'($urandom), (($urandom % 5) != 0), s, c,
                 "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule